// File: doc/BRIEF.md
# SPI Bus Sniffer

This block listens to a four-wire SPI bus without ever driving it. The serial clock, chip select and both data lines are oversampled by a much faster system clock. After resynchronisation the block finds the sampling edge of the serial clock from the clock polarity and phase chosen at run time. It captures the host-to-device and device-to-host lines together into two separate words.

When the configured number of bits has arrived, the block presents both words in the same cycle with a one-cycle strobe. A warning bit goes with them if any of the bits was taken while chip select was at its inactive level. Every change of the chip-select level is reported as its own event, with the old and the new level, whether or not the serial clock is moving. A running word counter is available for status. Polarity of chip select, bit order and word length (1 to 32 bits) are all run-time inputs. They are read only between words.

Top module: `spi_bus_monitor`

## Requirements
- R1: After reset, `word_valid`, `cs_evt` and `word_count` are all zero. The stored previous serial-clock level starts at 1, so a low clock seen right after reset counts as a falling edge.
- R2: Mode = {cfg_cpol, cfg_cpha}. Modes 0 (00) and 3 (11) capture on the rising edge of `sck_i`. Modes 1 (01) and 2 (10) capture on the falling edge. The other edge has no effect on the captured data.
- R3: On each capture edge, `mosi_i` and `miso_i` are both taken, each into its own word. The two words of a pair complete together.
- R4: With `cfg_lsb_first` = 0, the bit captured k-th (k from 0) lands at bit position (L−1−k), where L = `cfg_len_m1`+1.
- R5: With `cfg_lsb_first` = 1, the bit captured k-th lands at bit position k.
- R6: A word completes on its L-th capture edge, for any L from 1 to 32. Bits at position L and above of the reported words are zero. The bit counter, both accumulators and the warning flag then return to zero.
- R7: `word_valid` is high for exactly one cycle. `word_mosi`, `word_miso` and `word_cs_warn` are valid in that cycle. The strobe appears on the third rising system-clock edge after the input change that forms the final capture edge.
- R8: `cfg_cs_act_high` = 0 makes chip select active low; 1 makes it active high. `word_cs_warn` is 1 if and only if at least one bit of that word was captured while `cs_i` was at its inactive level. The flag does not carry into the next word.
- R9: Each change of the synchronised `cs_i` level gives a one-cycle `cs_evt`, with `cs_evt_prev` and `cs_evt_new` holding the old and new levels. This takes three system-clock edges after the input change and needs no `sck_i` activity.
- R10: `word_count` rises by one with each `word_valid` and is otherwise unchanged.
- R11: Configuration inputs are taken only while no word is in progress. A change of bit order or length after the first capture edge of a word does not affect that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the SPI clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Observed serial clock |
| cs_i | input | 1 | Observed chip select |
| mosi_i | input | 1 | Observed host-to-device data |
| miso_i | input | 1 | Observed device-to-host data |
| cfg_cpol | input | 1 | Clock idle level |
| cfg_cpha | input | 1 | Clock phase: 0 captures on the leading edge, 1 on the trailing edge |
| cfg_lsb_first | input | 1 | 1 = first bit is the least significant |
| cfg_cs_act_high | input | 1 | 1 = chip select active high |
| cfg_len_m1 | input | LW (5) | Word length minus one |
| word_valid | output | 1 | One-cycle completion strobe |
| word_mosi | output | MAXW (32) | Completed host-to-device word |
| word_miso | output | MAXW (32) | Completed device-to-host word |
| word_cs_warn | output | 1 | Chip select was inactive during the word |
| word_count | output | CNTW (16) | Completed-word counter |
| cs_evt | output | 1 | One-cycle chip-select change strobe |
| cs_evt_prev | output | 1 | Chip-select level before the change |
| cs_evt_new | output | 1 | Chip-select level after the change |

## Verification
The hardest case to reach from the ports is a configuration change in the middle of a word. Only the block's bit counter decides whether the change is honoured, and that counter is not visible. The stimulus starts a word, changes both bit order and length after the third capture edge, and checks that the word still comes out in the original order and length. A second hard case is a chip-select glitch lasting a single bit inside a word, which must raise the warning for that word and not for the next. Mode changes are ordered so that moving the clock to its new idle level never forms a capture edge in the new mode.

// File: rtl/spi_bus_monitor.sv
module spi_bus_monitor #(
  parameter int MAXW = 32,
  parameter int CNTW = 16,
  localparam int LW = (MAXW > 1) ? $clog2(MAXW) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sck_i,
  input  logic            cs_i,
  input  logic            mosi_i,
  input  logic            miso_i,
  input  logic            cfg_cpol,
  input  logic            cfg_cpha,
  input  logic            cfg_lsb_first,
  input  logic            cfg_cs_act_high,
  input  logic [LW-1:0]   cfg_len_m1,
  output logic            word_valid,
  output logic [MAXW-1:0] word_mosi,
  output logic [MAXW-1:0] word_miso,
  output logic            word_cs_warn,
  output logic [CNTW-1:0] word_count,
  output logic            cs_evt,
  output logic            cs_evt_prev,
  output logic            cs_evt_new
);

  logic [1:0] sck_sy, cs_sy, mosi_sy, miso_sy;
  logic       sck_s, cs_s, mosi_s, miso_s;
  logic       sck_prev, cs_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sy  <= 2'b11;
      cs_sy   <= 2'b11;
      mosi_sy <= 2'b00;
      miso_sy <= 2'b00;
    end else begin
      sck_sy  <= {sck_sy[0], sck_i};
      cs_sy   <= {cs_sy[0], cs_i};
      mosi_sy <= {mosi_sy[0], mosi_i};
      miso_sy <= {miso_sy[0], miso_i};
    end
  end

  assign sck_s  = sck_sy[1];
  assign cs_s   = cs_sy[1];
  assign mosi_s = mosi_sy[1];
  assign miso_s = miso_sy[1];

  logic [LW-1:0] bcnt, len_q;
  logic          cpol_q, cpha_q, lsb_q, csh_q;
  logic          idle;

  assign idle = (bcnt == '0);

  logic          cpol_e, cpha_e, lsb_e, csh_e;
  logic [LW-1:0] len_e;

  assign cpol_e = idle ? cfg_cpol        : cpol_q;
  assign cpha_e = idle ? cfg_cpha        : cpha_q;
  assign lsb_e  = idle ? cfg_lsb_first   : lsb_q;
  assign csh_e  = idle ? cfg_cs_act_high : csh_q;
  assign len_e  = idle ? cfg_len_m1      : len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpol_q <= 1'b0;
      cpha_q <= 1'b0;
      lsb_q  <= 1'b0;
      csh_q  <= 1'b0;
      len_q  <= '0;
    end else if (idle) begin
      cpol_q <= cfg_cpol;
      cpha_q <= cfg_cpha;
      lsb_q  <= cfg_lsb_first;
      csh_q  <= cfg_cs_act_high;
      len_q  <= cfg_len_m1;
    end
  end

  logic rise, fall, take, last, cs_off;
  logic [LW-1:0]   pos;
  logic [MAXW-1:0] mosi_acc, miso_acc, mosi_nx, miso_nx;
  logic            warn_q, warn_nx;

  assign rise    = sck_s & ~sck_prev;
  assign fall    = ~sck_s & sck_prev;
  assign take    = (cpol_e ^ cpha_e) ? fall : rise;
  assign last    = (bcnt == len_e);
  assign pos     = lsb_e ? bcnt : (len_e - bcnt);
  assign mosi_nx = mosi_acc | ({{(MAXW-1){1'b0}}, mosi_s} << pos);
  assign miso_nx = miso_acc | ({{(MAXW-1){1'b0}}, miso_s} << pos);
  assign cs_off  = csh_e ? ~cs_s : cs_s;
  assign warn_nx = warn_q | cs_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_prev     <= 1'b1;
      bcnt         <= '0;
      mosi_acc     <= '0;
      miso_acc     <= '0;
      warn_q       <= 1'b0;
      word_valid   <= 1'b0;
      word_mosi    <= '0;
      word_miso    <= '0;
      word_cs_warn <= 1'b0;
      word_count   <= '0;
    end else begin
      sck_prev   <= sck_s;
      word_valid <= 1'b0;
      if (take) begin
        if (last) begin
          word_valid   <= 1'b1;
          word_mosi    <= mosi_nx;
          word_miso    <= miso_nx;
          word_cs_warn <= warn_nx;
          word_count   <= word_count + 1'b1;
          bcnt         <= '0;
          mosi_acc     <= '0;
          miso_acc     <= '0;
          warn_q       <= 1'b0;
        end else begin
          bcnt     <= bcnt + 1'b1;
          mosi_acc <= mosi_nx;
          miso_acc <= miso_nx;
          warn_q   <= warn_nx;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_prev     <= 1'b1;
      cs_evt      <= 1'b0;
      cs_evt_prev <= 1'b1;
      cs_evt_new  <= 1'b1;
    end else begin
      cs_prev <= cs_s;
      cs_evt  <= (cs_s != cs_prev);
      if (cs_s != cs_prev) begin
        cs_evt_prev <= cs_prev;
        cs_evt_new  <= cs_s;
      end
    end
  end

endmodule

// File: rtl/spi_bus_monitor_chk.sv
module spi_bus_monitor_chk #(
  parameter int MAXW = 32,
  parameter int CNTW = 16,
  parameter int LW   = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            word_valid,
  input logic [CNTW-1:0] word_count,
  input logic            cs_evt,
  input logic            cs_evt_prev,
  input logic            cs_evt_new,
  input logic [LW-1:0]   bcnt,
  input logic [LW-1:0]   len_q
);

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid); // R7

  AST_COUNT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> word_count == CNTW'($past(word_count) + 1'b1)); // R10

  AST_COUNT_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid |-> $stable(word_count)); // R10

  AST_CS_EVT_DIFFERS: assert property (@(posedge clk) disable iff (!rst_n)
    cs_evt |-> (cs_evt_new != cs_evt_prev)); // R9

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (bcnt != '0 && $past(bcnt) != '0) |-> $stable(len_q)); // R11

endmodule

bind spi_bus_monitor spi_bus_monitor_chk #(.MAXW(MAXW), .CNTW(CNTW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_count(word_count),
  .cs_evt(cs_evt), .cs_evt_prev(cs_evt_prev), .cs_evt_new(cs_evt_new),
  .bcnt(bcnt), .len_q(len_q)
);

// File: tb/sim_spi_bus_monitor.sv
`timescale 1ns/1ps
module sim_spi_bus_monitor;
  localparam int MAXW = 32;
  localparam int CNTW = 16;
  localparam int LW   = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck_i = 1'b0, cs_i = 1'b1, mosi_i = 1'b0, miso_i = 1'b0;
  logic cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_lsb_first = 1'b0, cfg_cs_act_high = 1'b0;
  logic [LW-1:0] cfg_len_m1 = 5'd7;
  logic word_valid, word_cs_warn, cs_evt, cs_evt_prev, cs_evt_new;
  logic [MAXW-1:0] word_mosi, word_miso;
  logic [CNTW-1:0] word_count;

  always #2 clk = ~clk;

  spi_bus_monitor #(.MAXW(MAXW), .CNTW(CNTW)) u0 (
    .clk(clk), .rst_n(rst_n), .sck_i(sck_i), .cs_i(cs_i), .mosi_i(mosi_i), .miso_i(miso_i),
    .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_lsb_first(cfg_lsb_first),
    .cfg_cs_act_high(cfg_cs_act_high), .cfg_len_m1(cfg_len_m1),
    .word_valid(word_valid), .word_mosi(word_mosi), .word_miso(word_miso),
    .word_cs_warn(word_cs_warn), .word_count(word_count),
    .cs_evt(cs_evt), .cs_evt_prev(cs_evt_prev), .cs_evt_new(cs_evt_new));

  int checks = 0, errors = 0;
  int nwords = 0, nevts = 0;
  logic [MAXW-1:0] got_mosi = '0, got_miso = '0;
  logic got_warn = 1'b0, got_prev = 1'b0, got_new = 1'b0, prev_valid = 1'b0;
  logic cs_act = 1'b0;

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always begin
    @(posedge clk); #1;
    if (rst_n) begin
      if (word_valid) begin
        nwords++;
        got_mosi = word_mosi;
        got_miso = word_miso;
        got_warn = word_cs_warn;
      end
      if (cs_evt) begin
        nevts++;
        got_prev = cs_evt_prev;
        got_new  = cs_evt_new;
      end
      if (word_valid && prev_valid) begin
        errors++; checks++;
        $display("FAIL R7 actual=%0h expected=%0h", 2, 1);
      end
      prev_valid = word_valid;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(input logic cpol, input logic cpha, input logic lsb, input int len);
    cfg_cpol = cpol; cfg_cpha = cpha; cfg_lsb_first = lsb; cfg_len_m1 = LW'(len - 1);
    tick(4);
    sck_i = cpol;
    tick(8);
  endtask

  task automatic send_word(input int len, input logic [31:0] mv, input logic [31:0] sv,
                           input int off_bit, input logic poke);
    logic save_lsb;
    logic [LW-1:0] save_len;
    save_lsb = cfg_lsb_first;
    save_len = cfg_len_m1;
    for (int k = 0; k < len; k++) begin
      int b;
      b = cfg_lsb_first ? k : len - 1 - k;
      if (poke && k == 3) begin
        cfg_lsb_first = ~save_lsb;
        cfg_len_m1 = 5'd3;
        b = save_lsb ? k : len - 1 - k;
      end else if (poke && k > 3) begin
        b = save_lsb ? k : len - 1 - k;
      end
      cs_i = (k == off_bit) ? ~cs_act : cs_act;
      if (!cfg_cpha) begin
        mosi_i = mv[b]; miso_i = sv[b];
        tick(4);
        sck_i = ~cfg_cpol;
        tick(4);
        sck_i = cfg_cpol;
      end else begin
        sck_i = ~cfg_cpol;
        mosi_i = mv[b]; miso_i = sv[b];
        tick(4);
        sck_i = cfg_cpol;
        tick(4);
      end
    end
    cs_i = cs_act;
    tick(8);
    cfg_lsb_first = save_lsb;
    cfg_len_m1 = save_len;
    tick(2);
  endtask

  function automatic logic [31:0] mask(input int len);
    return (len >= 32) ? 32'hFFFF_FFFF : ((32'd1 << len) - 1);
  endfunction

  typedef struct packed {
    logic        cpol;
    logic        cpha;
    logic        lsb;
    logic [5:0]  len;
    logic [31:0] mv;
    logic [31:0] sv;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{1'b0, 1'b0, 1'b0, 6'd8,  32'h0000_00A5, 32'h0000_003C},
    '{1'b0, 1'b1, 1'b0, 6'd8,  32'h0000_005A, 32'h0000_00C3},
    '{1'b0, 1'b0, 1'b1, 6'd16, 32'h0000_1234, 32'h0000_BEEF},
    '{1'b0, 1'b1, 1'b1, 6'd5,  32'h0000_0013, 32'h0000_000A},
    '{1'b1, 1'b0, 1'b0, 6'd8,  32'h0000_0081, 32'h0000_007E},
    '{1'b1, 1'b1, 1'b0, 6'd8,  32'h0000_00F0, 32'h0000_000F},
    '{1'b1, 1'b1, 1'b1, 6'd12, 32'h0000_0ABC, 32'h0000_0543},
    '{1'b1, 1'b0, 1'b0, 6'd32, 32'hDEAD_BEEF, 32'h0BAD_F00D},
    '{1'b1, 1'b0, 1'b1, 6'd1,  32'h0000_0001, 32'h0000_0000},
    '{1'b0, 1'b0, 1'b1, 6'd32, 32'h8000_0001, 32'h7FFF_FFFE}
  };

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick(4);
    // R1 reset state
    chk(word_valid == 1'b0, "R1 valid", 64'(word_valid), 0);
    chk(word_count == '0, "R1 count", 64'(word_count), 0);
    chk(cs_evt == 1'b0 && nevts == 0, "R1 cs_evt", 64'(nevts), 0);
    chk(nwords == 0, "R1 no word from low clock", 64'(nwords), 0);

    // R9 chip select change with the clock idle
    cs_i = 1'b0;
    tick(6);
    chk(nevts == 1, "R9 event count", 64'(nevts), 1);
    chk(got_prev == 1'b1 && got_new == 1'b0, "R9 levels", {got_prev, got_new}, 2'b10);

    // R2 R3 R4 R5 R6 table walk
    for (int i = 0; i < 10; i++) begin
      int n0, len;
      len = int'(VECS[i].len);
      set_mode(VECS[i].cpol, VECS[i].cpha, VECS[i].lsb, len);
      n0 = nwords;
      send_word(len, VECS[i].mv, VECS[i].sv, -1, 1'b0);
      chk(nwords == n0 + 1, "R6 one word", 64'(nwords - n0), 1);
      chk(got_mosi == (VECS[i].mv & mask(len)), VECS[i].lsb ? "R5 R2 mosi" : "R4 R2 mosi",
          64'(got_mosi), 64'(VECS[i].mv & mask(len)));
      chk(got_miso == (VECS[i].sv & mask(len)), "R3 miso", 64'(got_miso), 64'(VECS[i].sv & mask(len)));
      chk(got_warn == 1'b0, "R8 clean word", 64'(got_warn), 0);
      chk(word_count == CNTW'(nwords), "R10 count", 64'(word_count), 64'(nwords));
    end

    // R7 latency of a one-bit word
    set_mode(1'b0, 1'b0, 1'b0, 1);
    mosi_i = 1'b1; miso_i = 1'b0;
    tick(4);
    sck_i = 1'b1;
    tick(2);
    chk(word_valid == 1'b0, "R7 not yet", 64'(word_valid), 0);
    tick(1);
    chk(word_valid == 1'b1, "R7 strobe", 64'(word_valid), 1);
    chk(word_mosi == 32'h1, "R7 data with strobe", 64'(word_mosi), 1);
    tick(1);
    chk(word_valid == 1'b0, "R7 one cycle", 64'(word_valid), 0);
    sck_i = 1'b0;
    tick(6);

    // R8 single-bit chip select glitch, then a clean word
    set_mode(1'b0, 1'b0, 1'b0, 8);
    send_word(8, 32'h96, 32'h69, 2, 1'b0);
    chk(got_warn == 1'b1, "R8 glitch warns", 64'(got_warn), 1);
    chk(got_mosi == 32'h96, "R8 data kept", 64'(got_mosi), 32'h96);
    send_word(8, 32'h11, 32'h22, -1, 1'b0);
    chk(got_warn == 1'b0, "R8 flag cleared", 64'(got_warn), 0);

    // R8 active-high polarity
    cfg_cs_act_high = 1'b1; cs_act = 1'b1; cs_i = 1'b1;
    tick(8);
    send_word(8, 32'h3C, 32'hC3, -1, 1'b0);
    chk(got_warn == 1'b0, "R8 active high asserted", 64'(got_warn), 0);
    cs_act = 1'b0; cs_i = 1'b0;
    tick(8);
    send_word(8, 32'h3C, 32'hC3, -1, 1'b0);
    chk(got_warn == 1'b1, "R8 active high deasserted", 64'(got_warn), 1);
    cfg_cs_act_high = 1'b0;
    tick(8);

    // R11 configuration change mid-word
    send_word(8, 32'hA5, 32'h0F, -1, 1'b1);
    chk(got_mosi == 32'hA5, "R11 mosi unchanged", 64'(got_mosi), 32'hA5);
    chk(got_miso == 32'h0F, "R11 miso unchanged", 64'(got_miso), 32'h0F);

    // R9 two more changes
    begin
      int e0;
      e0 = nevts;
      cs_i = 1'b1; tick(6);
      cs_i = 1'b0; tick(6);
      chk(nevts == e0 + 2, "R9 two events", 64'(nevts - e0), 2);
      chk(got_prev == 1'b1 && got_new == 1'b0, "R9 last levels", {got_prev, got_new}, 2'b10);
    end

    chk(word_count == CNTW'(nwords), "R10 final count", 64'(word_count), 64'(nwords));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule